// File: doc/BRIEF.md
# Dual Auxiliary Pulse-Width Timer

This block drives two auxiliary pulse-width outputs whose frequency and duty cycle are both programmable. Each channel has a 16-bit period register and a 16-bit duty register. A channel's period lasts twice its period value plus one clock cycles. Its output is high for the first twice-duty-value cycles of each period. Software sets these values through a plain write port made of an enable, an address and a data word.

Writes go into staging registers. A channel copies its staging registers into its working registers only when its current period ends, so an update can never cut a pulse short or stretch it.

A mode bit chooses how the second channel runs. In independent mode the two channels run free of each other. In offset mode the second channel follows the first channel's counter, and its period register becomes a delay, in clock cycles, from the start of the first channel's period to the second channel's rising edge. This lets two outputs at the same frequency keep a fixed phase relation.

Top module: `aux_pwm_pair`

## Requirements
- R1: After reset every register is zero and both outputs are low. With all registers zero, each channel counts a period of 2 cycles and keeps its output low.
- R2: In independent mode, channel n repeats with a period of exactly 2 × (period_n + 1) clock cycles. Each channel uses only its own registers.
- R3: Within each period, a channel's output is high for the first 2 × duty_n cycles and low for the rest.
- R4: A duty value of 0 holds the output low. A duty value of period_n + 1 or more holds it high for the whole period.
- R5: A write to a period or duty register takes effect on the first cycle of that channel's next period. The period already running finishes with the old values.
- R6: The write address selects the target register: 0 is period 0, 1 is duty 0, 2 is period 1, 3 is duty 1, and 4 is the mode register, where data bit 0 set to 1 selects offset mode. Writes to addresses 5 to 7 change nothing.
- R7: In offset mode, channel 1 takes channel 0's period. Its output goes high when channel 0's cycle count within the period equals the offset held in period register 1. It stays high for 2 × duty_1 cycles, but is cut off at the end of channel 0's period. If the offset is at or beyond the period length, the output stays low.
- R8: A mode change takes effect at the start of channel 0's next period. Channel 1 loads its staged values at that same boundary. On a return to independent mode, channel 1 starts a fresh period at that boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one tick per cycle |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register select |
| wrData | input | 16 | Write data |
| pwmOut0 | output | 1 | Channel 0 pulse output |
| pwmOut1 | output | 1 | Channel 1 pulse output |

## Verification
In independent mode, channel 0's period value is swept from 0 to 3 against duty values from 0 to 5, while channel 1 runs another setting alongside. This separates the constant-low case, ordinary pulses, the exact full-on boundary at duty equal to period plus one, and leakage between channels. In offset mode the offset is swept across and past the shared period, with several duty values. This shows whether the rising edge lands on the programmed cycle and whether a long pulse is cut off at the period end. Writes land at arbitrary points within a period and the mode flips back and forth, which exposes any update that takes effect early. Writes to the unused addresses must leave both waveforms exactly as they were.

// File: rtl/aux_pwm_pkg.sv
package aux_pwm_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] ADR_PER0  = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_DUTY0 = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_PER1  = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_DUTY1 = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_MODE  = 3'd4;

  typedef struct packed {
    logic load0;    // channel 0 period end: restart counter, take staged values
    logic load1;    // channel 1 restart / take staged values
    logic loadMode; // latch staged mode bit
  } auxStrobes_t;
endpackage

// File: rtl/aux_pwm_ctrl.sv
module aux_pwm_ctrl
  import aux_pwm_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int CW = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CW-1:0]    cnt0,
  input  logic [CW-1:0]    cnt1,
  input  logic [CNT_W-1:0] actPer0,
  input  logic [CNT_W-1:0] actPer1,
  input  logic             modeAct,
  input  logic             modeStg,
  output auxStrobes_t      strb
);
  logic end0, end1;

  always_comb begin
    end0 = (cnt0 == {actPer0, 1'b1});
    end1 = !modeAct && (cnt1 == {actPer1, 1'b1});
    strb.load0    = end0;
    strb.loadMode = end0;
    strb.load1    = end1 || (end0 && (modeAct || modeStg));
  end

  // R8
  offset_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (modeAct && strb.load1) |-> strb.load0);
endmodule

// File: rtl/aux_pwm_datapath.sv
module aux_pwm_datapath
  import aux_pwm_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int CW = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  auxStrobes_t       strb,
  output logic [CW-1:0]     cnt0,
  output logic [CW-1:0]     cnt1,
  output logic [CNT_W-1:0]  actPer0,
  output logic [CNT_W-1:0]  actPer1,
  output logic              modeAct,
  output logic              modeStg,
  output logic              pwmOut0,
  output logic              pwmOut1
);
  logic [CNT_W-1:0] stgPer0, stgDuty0, stgPer1, stgDuty1;
  logic [CNT_W-1:0] actDuty0, actDuty1;
  logic [CW-1:0]    onLen0, onLen1, offExt, relCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      stgPer0 <= '0; stgDuty0 <= '0; stgPer1 <= '0; stgDuty1 <= '0; modeStg <= 1'b0;
    end else if (wrEn) begin
      case (wrAddr)
        ADR_PER0:  stgPer0  <= wrData;
        ADR_DUTY0: stgDuty0 <= wrData;
        ADR_PER1:  stgPer1  <= wrData;
        ADR_DUTY1: stgDuty1 <= wrData;
        ADR_MODE:  modeStg  <= wrData[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt0 <= '0; actPer0 <= '0; actDuty0 <= '0; modeAct <= 1'b0;
    end else if (strb.load0) begin
      cnt0 <= '0; actPer0 <= stgPer0; actDuty0 <= stgDuty0; modeAct <= modeStg;
    end else begin
      cnt0 <= cnt0 + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt1 <= '0; actPer1 <= '0; actDuty1 <= '0;
    end else begin
      if (strb.load1) begin
        actPer1 <= stgPer1; actDuty1 <= stgDuty1;
      end
      cnt1 <= (modeAct || strb.load1) ? '0 : cnt1 + 1'b1;
    end
  end

  always_comb begin
    onLen0  = {actDuty0, 1'b0};
    onLen1  = {actDuty1, 1'b0};
    offExt  = {1'b0, actPer1};
    relCnt  = cnt0 - offExt;
    pwmOut0 = cnt0 < onLen0;
    if (modeAct) pwmOut1 = (cnt0 >= offExt) && (relCnt < onLen1);
    else         pwmOut1 = cnt1 < onLen1;
  end

  // R2
  cnt0_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt0 <= {actPer0, 1'b1});
  // R4
  duty_zero_low_chk: assert property (@(posedge clk) disable iff (rst)
    (actDuty0 == '0) |-> !pwmOut0);
  // R5
  shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strb.load0 |=> $stable(actPer0) && $stable(actDuty0));
  // R8
  offset_cnt1_idle_chk: assert property (@(posedge clk) disable iff (rst)
    modeAct |-> (cnt1 == '0));
endmodule

// File: rtl/aux_pwm_pair.sv
module aux_pwm_pair
  import aux_pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  output logic              pwmOut0,
  output logic              pwmOut1
);
  localparam int CW = CNT_W + 1;

  auxStrobes_t      strb;
  logic [CW-1:0]    cnt0, cnt1;
  logic [CNT_W-1:0] actPer0, actPer1;
  logic             modeAct, modeStg;

  aux_pwm_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rst(rst), .cnt0(cnt0), .cnt1(cnt1),
    .actPer0(actPer0), .actPer1(actPer1),
    .modeAct(modeAct), .modeStg(modeStg), .strb(strb)
  );

  aux_pwm_datapath #(.CNT_W(CNT_W)) uData (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strb(strb), .cnt0(cnt0), .cnt1(cnt1), .actPer0(actPer0), .actPer1(actPer1),
    .modeAct(modeAct), .modeStg(modeStg), .pwmOut0(pwmOut0), .pwmOut1(pwmOut1)
  );

  // R1
  reset_low_chk: assert property (@(posedge clk) $past(rst) |-> !pwmOut0 && !pwmOut1);
endmodule

// File: tb/aux_pwm_pair_test.sv
module aux_pwm_pair_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [15:0] wrData = '0;
  logic pwmOut0, pwmOut1;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  bit checking = 1'b0;
  string phaseReq = "R1";

  always #5 clk = ~clk;

  aux_pwm_pair uut (.clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr),
                    .wrData(wrData), .pwmOut0(pwmOut0), .pwmOut1(pwmOut1));

  // Expected-waveform model built from the requirement text (cycle counts in ints)
  int mc0, mc1, sP0, sD0, sP1, sD1, aP0, aD0, aP1, aD1;
  bit sM, aM;
  always @(posedge clk) begin
    bit e0, e1, c1;
    if (rst) begin
      mc0 <= 0; mc1 <= 0; sP0 <= 0; sD0 <= 0; sP1 <= 0; sD1 <= 0;
      aP0 <= 0; aD0 <= 0; aP1 <= 0; aD1 <= 0; sM <= 0; aM <= 0;
    end else begin
      if (wrEn) begin   // R6 address map
        if (wrAddr == 0) sP0 <= int'(wrData);
        if (wrAddr == 1) sD0 <= int'(wrData);
        if (wrAddr == 2) sP1 <= int'(wrData);
        if (wrAddr == 3) sD1 <= int'(wrData);
        if (wrAddr == 4) sM  <= wrData[0];
      end
      e0 = (mc0 == 2 * (aP0 + 1) - 1);                 // R2 period length
      e1 = !aM && (mc1 == 2 * (aP1 + 1) - 1);
      c1 = e1 || (e0 && (aM || sM));                   // R8 boundary
      if (e0) begin mc0 <= 0; aP0 <= sP0; aD0 <= sD0; aM <= sM; end  // R5
      else mc0 <= mc0 + 1;
      if (c1) begin aP1 <= sP1; aD1 <= sD1; end
      mc1 <= (aM || c1) ? 0 : mc1 + 1;
    end
  end

  function automatic bit expOut1();
    if (aM) return (mc0 >= aP1) && (mc0 - aP1 < 2 * aD1);  // R7
    return mc1 < 2 * aD1;                                   // R3/R4
  endfunction

  always @(negedge clk) begin
    if (checking && !done) begin
      bit x0, x1;
      x0 = (mc0 < 2 * aD0);
      x1 = expOut1();
      checks++;
      if (pwmOut0 !== x0) begin
        errors++;
        $display("FAIL %s ch0 at t=%0t: actual=%b expected=%b", phaseReq, $time, pwmOut0, x0);
      end
      checks++;
      if (pwmOut1 !== x1) begin
        errors++;
        $display("FAIL %s ch1 at t=%0t: actual=%b expected=%b", phaseReq, $time, pwmOut1, x1);
      end
    end
  end

  task automatic writeReg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic runCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state, outputs low and explicit low check
    phaseReq = "R1";
    checking = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      checks++;
      if (pwmOut0 !== 1'b0 || pwmOut1 !== 1'b0) begin
        errors++;
        $display("FAIL R1 outputs after reset: actual=%b%b expected=00", pwmOut0, pwmOut1);
      end
    end
    // R2/R3/R4/R5: independent sweep incl. full-on boundary duty = period+1
    phaseReq = "R2/R3/R4/R5";
    for (int p = 0; p < 4; p++) begin
      for (int d = 0; d < 6; d++) begin
        writeReg(3'd0, 16'(p));
        runCycles(d % 3);
        writeReg(3'd1, 16'(d));
        writeReg(3'd2, 16'((p + d) % 4));
        writeReg(3'd3, 16'(5 - d));
        runCycles(22);
      end
    end
    // R6: unused addresses ignored; waveform keeps matching unchanged model
    phaseReq = "R6";
    writeReg(3'd5, 16'hFFFF);
    writeReg(3'd6, 16'h0001);
    writeReg(3'd7, 16'h0003);
    runCycles(30);
    // R7/R8: offset mode sweep over offset and duty on a shared period
    phaseReq = "R7/R8";
    writeReg(3'd0, 16'd4);
    writeReg(3'd1, 16'd2);
    writeReg(3'd4, 16'd1);
    for (int off = 0; off < 12; off++) begin
      for (int d1 = 0; d1 < 7; d1 += 2) begin
        writeReg(3'd2, 16'(off));
        writeReg(3'd3, 16'(d1));
        runCycles(21);
      end
    end
    // R8: return to independent mode, channel 1 restarts at ch0 boundary
    phaseReq = "R8";
    writeReg(3'd2, 16'd2);
    writeReg(3'd3, 16'd1);
    writeReg(3'd4, 16'd0);
    runCycles(40);
    writeReg(3'd4, 16'd1);
    runCycles(25);
    writeReg(3'd4, 16'd0);
    runCycles(25);
    checking = 1'b0;
    finishRun();
  end
endmodule